// File: doc/BRIEF.md
# Event Timer with Power-Down Wake

The block is a timer/counter that counts falling edges of an external count pin. Outside power-down it samples the pin on two machine-cycle phase strobes. The early strobe captures the pin into a first detector stage. The late strobe moves that sample into a second stage. A count occurs when the second stage holds a high and the new first-stage sample is low. Four modes select how the count register behaves:
- a 13-bit counter
- a 16-bit counter
- an 8-bit counter that reloads from the upper byte
- a split form with two independent 8-bit counters

In soft power-down the machine strobes stop. The pin then reaches the counter directly through a gate, so events are still counted. In the 13-bit and 16-bit modes, an overflow during power-down ends power-down and raises a one-cycle wake request. Power-down can also be left by an external wake input or by reset.

The block reproduces a known artefact of this arrangement. When power-down ends while the pin is high, the gate output drops from 1 to 0 and adds one count. The detector stages were held cleared during power-down. They therefore see the later falling edge of the same high pulse as a new event and add a second count. System software is expected to correct for this, either by reloading the counter or by subtracting one. All ports are plain control and status signals; there is no streaming interface and no back-pressure.

Top module: `evt_timer`

## Requirements
- R1: While `rst_n` is low, `count_o` is 0 and `ovf_flag`, `ovf_flag_hi`, `pd_o` and `wake_o` are all 0.
- R2: Outside power-down, with `run` high, the counter advances by one in the cycle after a `s5_stb` pulse. This happens only when the pin sample taken at the previous `s3_stb` was high and the sample taken at the latest `s3_stb` is low. With `run` low, no pin event changes the count.
- R3: `mode` encodings: 0 selects a 13-bit count that wraps from 0x1FFF to 0 with bits 15:13 kept at zero, and 1 selects a 16-bit count that wraps from 0xFFFF to 0.
- R4: Mode 2 counts in bits 7:0. On an event at 0xFF, outside power-down, bits 7:0 reload from bits 15:8. During power-down they wrap to 0 without reload.
- R5: Mode 3: bits 7:0 count pin events and wrap at 0xFF. Bits 15:8 advance on every `s5_stb` while `run` is high and power-down is off. Their wrap sets `ovf_flag_hi`.
- R6: A counted event at the mode's all-ones value sets `ovf_flag`. The flag stays set until a `flag_clr` cycle in which no new overflow occurs.
- R7: A one-cycle `pd_req` enters power-down (`pd_o` high next cycle). While in power-down, each high-to-low change of `cnt_pin` between consecutive clocks adds one count when `run` is high. The detector stages are held cleared.
- R8: `ext_wake` in power-down clears `pd_o` next cycle. If `cnt_pin` is high then, the count rises by one in the first cycle out of power-down. The following falling pin edge adds one more count through the detector.
- R9: In modes 0 or 1, with `run` high, power-down on, the count at all-ones and `cnt_pin` high, `pd_o` clears and `wake_o` pulses for exactly one cycle. In the same cycle `ovf_flag` sets, and the count then wraps to 0.
- R10: In modes 2 and 3, `wake_o` never asserts and overflow does not end power-down.
- R11: `load_en` writes `load_val` into the count in the next cycle and overrides any event in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s3_stb | input | 1 | Early machine-phase strobe (pin sample) |
| s5_stb | input | 1 | Late machine-phase strobe (second stage, count) |
| cnt_pin | input | 1 | External count pin |
| mode | input | 2 | Counter mode 0..3 |
| run | input | 1 | Count enable |
| pd_req | input | 1 | Enter power-down |
| ext_wake | input | 1 | External interrupt ending power-down |
| load_en | input | 1 | Write load_val into the count |
| load_val | input | 16 | Value to load |
| flag_clr | input | 1 | Clear both overflow flags |
| count_o | output | 16 | Count register |
| ovf_flag | output | 1 | Main overflow flag |
| ovf_flag_hi | output | 1 | Upper-byte overflow flag (mode 3) |
| wake_o | output | 1 | One-cycle wake request |
| pd_o | output | 1 | Power-down active |

## Verification
Several properties are checked on every cycle:
- the count holds when no event, strobe or load is present;
- bits 15:13 stay zero in mode 0;
- the detector stages are cleared during power-down;
- `wake_o` is a single-cycle pulse that only follows a power-down in mode 0 or 1;
- power-down ends only after a wake cause.

The exact amount of each count, including both extra increments after a wake with the pin high, can only be shown by the bench's scenarios. The same holds for the reload-versus-wrap choice in mode 2 and the three wake cases (pin low, pin high, overflow).

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  typedef enum logic [1:0] {
    MODE_13    = 2'd0,
    MODE_16    = 2'd1,
    MODE_8R    = 2'd2,
    MODE_SPLIT = 2'd3
  } tmr_mode_e;
endpackage

// File: rtl/evt_edge_det.sv
module evt_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic s3_stb,
  input  logic s5_stb,
  input  logic pin,
  input  logic pd,
  output logic tick
);
  logic st1_q, st2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st1_q <= 1'b0;
      st2_q <= 1'b0;
    end else if (pd) begin
      st1_q <= 1'b0;
      st2_q <= 1'b0;
    end else begin
      if (s3_stb) st1_q <= pin;
      if (s5_stb) st2_q <= st1_q;
    end
  end

  assign tick = s5_stb & st2_q & ~st1_q & ~pd;

  // R7: detector stages are cleared while in power-down
  p_stage_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pd |=> (!st1_q && !st2_q));
endmodule

// File: rtl/evt_pd_ctrl.sv
module evt_pd_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic pd_req,
  input  logic ext_wake,
  input  logic ovf_wake,
  output logic pd_q,
  output logic wake_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_q   <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      wake_q <= pd_q & ovf_wake;
      if (pd_q && (ext_wake || ovf_wake)) pd_q <= 1'b0;
      else if (!pd_q && pd_req)           pd_q <= 1'b1;
    end
  end

  p_wake_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_q |=> !wake_q);
  p_pd_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pd_q) |-> $past(ext_wake || ovf_wake));
endmodule

// File: rtl/evt_count_core.sv
module evt_count_core
  import evt_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int M0_W  = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tmr_mode_e        mode,
  input  logic             ev,
  input  logic             hi_tick,
  input  logic             pd,
  input  logic             ovf_wake,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] cnt_q,
  output logic             full,
  output logic             flag_q,
  output logic             flag_hi_q
);
  localparam int HW = CNT_W / 2;

  logic [CNT_W-1:0] nxt;
  logic [M0_W-1:0]  lo13_inc;
  logic [HW-1:0]    lo_inc, hi_inc, lo8_next;
  logic             wrap, hwrap;

  assign lo13_inc = cnt_q[M0_W-1:0] + 1'b1;
  assign lo_inc   = cnt_q[HW-1:0] + 1'b1;
  assign hi_inc   = cnt_q[CNT_W-1:HW] + 1'b1;

  always_comb begin
    case (mode)
      MODE_13: full = &cnt_q[M0_W-1:0];
      MODE_16: full = &cnt_q;
      default: full = &cnt_q[HW-1:0];
    endcase
  end

  always_comb begin
    nxt      = cnt_q;
    wrap     = 1'b0;
    hwrap    = 1'b0;
    lo8_next = lo_inc;
    if (mode == MODE_8R && full) lo8_next = pd ? '0 : cnt_q[CNT_W-1:HW];
    if (load_en) begin
      nxt = load_val;
    end else begin
      wrap = ev & full;
      case (mode)
        MODE_13: if (ev) nxt = {{(CNT_W-M0_W){1'b0}}, lo13_inc};
        MODE_16: if (ev) nxt = cnt_q + 1'b1;
        MODE_8R: if (ev) nxt[HW-1:0] = lo8_next;
        default: begin
          if (ev) nxt[HW-1:0] = lo_inc;
          if (hi_tick) begin
            nxt[CNT_W-1:HW] = hi_inc;
            hwrap = &cnt_q[CNT_W-1:HW];
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      flag_q    <= 1'b0;
      flag_hi_q <= 1'b0;
    end else begin
      cnt_q <= nxt;
      if (wrap || ovf_wake) flag_q <= 1'b1;
      else if (flag_clr)    flag_q <= 1'b0;
      if (hwrap)            flag_hi_q <= 1'b1;
      else if (flag_clr)    flag_hi_q <= 1'b0;
    end
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && !ev && !hi_tick) |=> $stable(cnt_q));
  p_m0_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_13 && !load_en && cnt_q[CNT_W-1:M0_W] == '0) |=> (cnt_q[CNT_W-1:M0_W] == '0));
  p_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && ev && full) |=> flag_q);
endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int M0_W  = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s3_stb,
  input  logic             s5_stb,
  input  logic             cnt_pin,
  input  logic [1:0]       mode,
  input  logic             run,
  input  logic             pd_req,
  input  logic             ext_wake,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_flag,
  output logic             ovf_flag_hi,
  output logic             wake_o,
  output logic             pd_o
);
  tmr_mode_e mode_e;
  logic pd_q, tick, gate, gate_q, gate_fall, ev, hi_tick, full, ovf_wake;

  assign mode_e = tmr_mode_e'(mode);

  evt_edge_det u_det (
    .clk(clk), .rst_n(rst_n), .s3_stb(s3_stb), .s5_stb(s5_stb),
    .pin(cnt_pin), .pd(pd_q), .tick(tick)
  );

  // power-down path: pin drives the counter through a gate
  assign gate = pd_q & cnt_pin;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= gate;
  end
  assign gate_fall = gate_q & ~gate;

  assign ev       = run & (gate_fall | tick);
  assign hi_tick  = run & s5_stb & ~pd_q;
  assign ovf_wake = pd_q & run & ~mode[1] & full & gate;

  evt_count_core #(.CNT_W(CNT_W), .M0_W(M0_W)) u_core (
    .clk(clk), .rst_n(rst_n), .mode(mode_e), .ev(ev), .hi_tick(hi_tick),
    .pd(pd_q), .ovf_wake(ovf_wake), .load_en(load_en), .load_val(load_val),
    .flag_clr(flag_clr), .cnt_q(count_o), .full(full), .flag_q(ovf_flag),
    .flag_hi_q(ovf_flag_hi)
  );

  evt_pd_ctrl u_pd (
    .clk(clk), .rst_n(rst_n), .pd_req(pd_req), .ext_wake(ext_wake),
    .ovf_wake(ovf_wake), .pd_q(pd_q), .wake_q(wake_o)
  );

  assign pd_o = pd_q;

  p_no_wake_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> ($past(mode[1]) == 1'b0));
  p_wake_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> (!pd_o && ovf_flag));
endmodule

// File: tb/sim_evt_timer.sv
`timescale 1ns/1ps
module sim_evt_timer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic s3 = 0, s5 = 0, pin = 0, run = 0, pd_req = 0, ext_wake = 0;
  logic load_en = 0, flag_clr = 0;
  logic [1:0]  mode = 2'd1;
  logic [15:0] load_val = '0;
  logic [15:0] count_o;
  logic ovf_flag, ovf_flag_hi, wake_o, pd_o;

  int checks = 0, errors = 0, cyc = 0, wake_seen = 0;
  string tag = "R1";

  // reference model state
  int m_cnt, m_fl, m_flh, m_pd, m_wk, m_st1, m_st2, m_gq;

  evt_timer u0 (
    .clk(clk), .rst_n(rst_n), .s3_stb(s3), .s5_stb(s5), .cnt_pin(pin),
    .mode(mode), .run(run), .pd_req(pd_req), .ext_wake(ext_wake),
    .load_en(load_en), .load_val(load_val), .flag_clr(flag_clr),
    .count_o(count_o), .ovf_flag(ovf_flag), .ovf_flag_hi(ovf_flag_hi),
    .wake_o(wake_o), .pd_o(pd_o)
  );

  always #4 clk = ~clk;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    int g, fall, tk, ev, top, nc, lo, ow, ns1, ns2;
    cyc++;
    if (!rst_n) begin
      m_cnt = 0; m_fl = 0; m_flh = 0; m_pd = 0; m_wk = 0; m_st1 = 0; m_st2 = 0; m_gq = 0;
    end else begin
      g    = (m_pd != 0 && pin) ? 1 : 0;
      fall = (m_gq == 1 && g == 0) ? 1 : 0;
      tk   = (m_pd == 0 && s5 && m_st2 == 1 && m_st1 == 0) ? 1 : 0;
      ev   = (run && (fall || tk)) ? 1 : 0;
      if (mode == 0)      top = ((m_cnt % 8192) == 8191) ? 1 : 0;
      else if (mode == 1) top = (m_cnt == 65535) ? 1 : 0;
      else                top = ((m_cnt % 256) == 255) ? 1 : 0;
      ow = (m_pd != 0 && run && mode < 2 && top == 1 && g == 1) ? 1 : 0;
      nc = m_cnt;
      if (load_en) nc = load_val;
      else begin
        if (ev) begin
          if (mode == 0) nc = (m_cnt % 8192 + 1) % 8192;
          else if (mode == 1) nc = (m_cnt + 1) % 65536;
          else begin
            lo = (m_cnt % 256) + 1;
            if (lo == 256) lo = (mode == 2 && m_pd == 0) ? m_cnt / 256 : 0;
            nc = (m_cnt / 256) * 256 + lo;
          end
          if (top) m_fl = 1;
        end
        if (mode == 3 && run && s5 && m_pd == 0) begin
          if (m_cnt / 256 == 255) m_flh = 1;
          nc = (nc % 256) + ((m_cnt / 256 + 1) % 256) * 256;
        end
      end
      if (ow) m_fl = 1;
      if (flag_clr && !(ev && top && !load_en) && !ow) m_fl = 0;
      if (flag_clr && !(mode == 3 && run && s5 && m_pd == 0 && m_cnt / 256 == 255 && !load_en)) m_flh = 0;
      ns1 = m_st1; ns2 = m_st2;
      if (m_pd != 0) begin ns1 = 0; ns2 = 0; end
      else begin
        if (s3) ns1 = pin;
        if (s5) ns2 = m_st1;
      end
      m_st1 = ns1; m_st2 = ns2;
      m_gq = g;
      m_wk = (m_pd != 0 && ow) ? 1 : 0;
      if (m_pd != 0 && (ext_wake || ow)) m_pd = 0;
      else if (m_pd == 0 && pd_req) m_pd = 1;
      m_cnt = nc;
    end
  end

  // compare every cycle away from the edge
  always @(negedge clk) begin
    if (rst_n) begin
      check({tag, " count"}, count_o, m_cnt);
      check({tag, " flag"}, ovf_flag, m_fl);
      check({tag, " flag_hi"}, ovf_flag_hi, m_flh);
      check({tag, " pd"}, pd_o, m_pd);
      check({tag, " wake"}, wake_o, m_wk);
      if (wake_o) wake_seen++;
    end
  end

  // machine phase strobes, stopped in power-down
  initial begin
    int ph = 0;
    forever begin
      @(posedge clk); #2;
      ph = (ph + 1) % 6;
      s3 = (ph == 2 && m_pd == 0);
      s5 = (ph == 4 && m_pd == 0);
    end
  end

  initial begin
    #160000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #2; end
  endtask
  task automatic pulse_pin(int hold);
    pin = 1; step(hold); pin = 0; step(hold);
  endtask
  task automatic do_load(int v);
    load_val = v[15:0]; load_en = 1; step(1); load_en = 0;
  endtask
  task automatic clr; flag_clr = 1; step(1); flag_clr = 0; endtask
  task automatic enter_pd; pd_req = 1; step(1); pd_req = 0; step(1); endtask
  task automatic wake_ext; ext_wake = 1; step(1); ext_wake = 0; step(2); endtask

  initial begin
    step(3); #1;
    check("R1 count", count_o, 0); check("R1 flag", ovf_flag, 0);
    check("R1 pd", pd_o, 0); check("R1 wake", wake_o, 0);
    rst_n = 1; step(2);

    tag = "R2"; mode = 1; pulse_pin(12); check("R2 no run", count_o, 0);
    run = 1;
    for (int k = 0; k < 3; k++) pulse_pin(12);
    check("R2 three edges", count_o, 3);

    tag = "R3"; mode = 0; do_load('h1FFE); pulse_pin(12); pulse_pin(12);
    check("R3 13-bit wrap", count_o, 0); check("R6 flag", ovf_flag, 1);
    tag = "R6"; clr; check("R6 cleared", ovf_flag, 0);
    tag = "R3"; mode = 1; do_load('hFFFF); pulse_pin(12);
    check("R3 16-bit wrap", count_o, 0); clr;

    tag = "R4"; mode = 2; do_load('h05FE);
    for (int k = 0; k < 3; k++) pulse_pin(12);
    check("R4 reload", count_o, 'h0506); clr;

    tag = "R5"; mode = 3; do_load('hFE00); pulse_pin(12); pulse_pin(12);
    check("R5 low byte", count_o % 256, 2); check("R5 hi flag", ovf_flag_hi, 1);
    clr;

    tag = "R11"; mode = 1; do_load('h0010); check("R11 load", count_o, 'h10);

    tag = "R7"; enter_pd; check("R7 pd on", pd_o, 1);
    pulse_pin(3); pulse_pin(3); check("R7 pd count", count_o, 'h12);
    tag = "R8"; wake_ext; check("R8 pin low wake", count_o, 'h12);
    pulse_pin(12); check("R8 normal after wake", count_o, 'h13);

    do_load('h0020); enter_pd; pin = 1; step(2); wake_ext;
    check("R8 pin high extra", count_o, 'h21);
    step(12); pin = 0; step(12); check("R8 second extra", count_o, 'h22);

    tag = "R9"; do_load('hFFFF); clr; wake_seen = 0; enter_pd; pin = 1; step(6);
    check("R9 wake once", wake_seen, 1); check("R9 pd off", pd_o, 0);
    check("R9 wrap", count_o, 0); check("R9 flag", ovf_flag, 1);
    step(6); pin = 0; step(12); check("R9 extra after ovf wake", count_o, 1);

    tag = "R10"; clr; mode = 2; do_load('h07FF); wake_seen = 0; enter_pd;
    pulse_pin(3); check("R4 pd no reload", count_o, 'h0700);
    check("R10 pd kept", pd_o, 1); check("R10 no wake", wake_seen, 0);
    wake_ext; step(4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule